// File: doc/BRIEF.md
# Dual-Clock Byte FIFO with Collision Flag

This block carries a byte stream from a writer clock domain to a reader clock domain through a circular store of 128 bytes. The two clocks may differ in phase, but they must run at the same average rate. The store only has to absorb short-term wander between them. Each domain keeps its own position counter. That counter crosses into the other domain as Gray code through a chain of flip-flops.

The reader does not hand out anything until the store is half full. After that point, every output slot that finds a byte delivers it, so a steady input produces an output with no gaps.

A collision has two forms. A write that meets a full store is an overrun. A read slot that meets an empty store is an underrun. Either form raises a level on a dedicated pin at once. It also sets a sticky event bit in the reader domain, which a host clears with a one-cycle strobe.

The reader runs a small state machine:
- `RD_FILL` is the state after reset.
- `RD_FILL` moves to `RD_RUN` when the reader sees at least START_LEVEL bytes stored.
- `RD_RUN` holds until reset.

The event bit is a second state machine:
- `EV_CLEAN` moves to `EV_LATCHED` on any collision.
- `EV_LATCHED` moves back to `EV_CLEAN` only on a clear strobe in a cycle with no collision.

Top module: `byte_link_fifo`

## Requirements
- R1: While both resets are low and right after them, `rd_valid`, `rd_data`, `collide` and `evt_flag` are all 0.
- R2: While the reader is in `RD_FILL` (fewer than 64 bytes seen stored since reset), read slots are ignored: `rd_valid` stays 0 and no underrun is reported.
- R3: In `RD_RUN`, a read slot that finds data gives `rd_valid`=1 on the next `rclk` edge, with bytes in the order they were written.
- R4: When the store is half full and one byte is written per `wclk` cycle while one slot is requested per `rclk` cycle, every slot delivers a byte and `collide` stays 0.
- R5: A write while 128 bytes are stored is dropped. From the next `wclk` edge, `collide` is 1 for as long as writes keep meeting a full store. Afterwards the stored 128 bytes read out unchanged.
- R6: A read slot in `RD_RUN` with the store empty gives `rd_valid`=0. `rd_data` keeps its last byte and `collide` is 1 from the next `rclk` edge.
- R7: Any collision sets `evt_flag`. It stays 1 after the condition ends, until `evt_clr` is pulsed.
- R8: If `evt_clr` and a collision fall in the same `rclk` cycle, `evt_flag` stays 1. A clear with no collision returns it to 0.
- R9: An underrun does not return the reader to `RD_FILL`: the next byte written is delivered on the next slot, without a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Writer clock |
| wrst_n | input | 1 | Writer domain asynchronous reset, active low |
| wr_valid | input | 1 | Offer `wr_data` for storage this cycle |
| wr_data | input | 8 | Byte to store |
| rclk | input | 1 | Reader clock |
| rrst_n | input | 1 | Reader domain asynchronous reset, active low |
| rd_slot | input | 1 | Output slot request this cycle |
| evt_clr | input | 1 | One-cycle clear of the sticky event (reader domain) |
| rd_valid | output | 1 | `rd_data` holds a fresh byte |
| rd_data | output | 8 | Output byte (held on underrun) |
| collide | output | 1 | Level: overrun or underrun occurring now |
| evt_flag | output | 1 | Sticky collision event |

## Verification
The clear strobe and a fresh collision can land on the same reader cycle, and the design must let the set win. The bench provokes this by keeping read slots going on an empty store while it pulses `evt_clr`. It judges the result by `evt_flag` still reading 1 at the next sample. It then repeats the clear with no slot pending and expects 0. Overrun and underrun can also overlap on the pin. Each is driven alone, and the pin level is checked to follow only the condition in force.

// File: rtl/bl_pkg.sv
package bl_pkg;

    // Reader sequencing: wait for half level, then stream.
    typedef enum logic {
        RD_FILL = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_t;

    // Sticky collision event.
    typedef enum logic {
        EV_CLEAN   = 1'b0,
        EV_LATCHED = 1'b1
    } evt_state_t;

    localparam int unsigned BL_DATA_W  = 8;
    localparam int unsigned BL_ADDR_W  = 7;
    localparam int unsigned BL_SYNC_N  = 2;

endpackage

// File: rtl/bl_sync.sv
module bl_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bl_store.sv
module bl_store #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 7
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/bl_wr_side.sv
module bl_wr_side #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wgray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              ovr_hit
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1 << ADDR_W);

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] wbin_q;
    logic [PTR_W-1:0] wbin_nx;
    logic [PTR_W-1:0] rbin_s;
    logic [PTR_W-1:0] used;
    logic             full;
    logic             accept;

    always_comb begin
        rbin_s  = g2b(rgray_sync);
        used    = wbin_q - rbin_s;
        full    = (used == DEPTH);
        accept  = wr_valid && !full;
        wbin_nx = accept ? wbin_q + 1'b1 : wbin_q;
    end

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin_q  <= '0;
            wgray   <= '0;
            ovr_hit <= 1'b0;
        end else begin
            wbin_q  <= wbin_nx;
            wgray   <= wbin_nx ^ (wbin_nx >> 1);
            ovr_hit <= wr_valid && full;
        end
    end

    assign mem_we    = accept;
    assign mem_waddr = wbin_q[ADDR_W-1:0];

    // R5: a blocked write leaves the write position in place
    a_r5_hold_wptr_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
        (wr_valid && full) |=> $stable(wbin_q));

    // R5: the writer never sees more than the capacity stored
    a_r5_level_bound: assert property (@(posedge wclk) disable iff (!wrst_n)
        used <= DEPTH);
endmodule

// File: rtl/bl_rd_side.sv
module bl_rd_side
    import bl_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned START_LEVEL = 64
) (
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_slot,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              urn_cond,
    output logic              urn_hit
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] START_LV = PTR_W'(START_LEVEL);

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    rd_state_t        state_q;
    rd_state_t        state_nx;
    logic [PTR_W-1:0] rbin_q;
    logic [PTR_W-1:0] rbin_nx;
    logic [PTR_W-1:0] wbin_s;
    logic [PTR_W-1:0] level;
    logic             empty;
    logic             take;

    always_comb begin
        wbin_s   = g2b(wgray_sync);
        level    = wbin_s - rbin_q;
        empty    = (level == '0);
        take     = 1'b0;
        urn_cond = 1'b0;
        state_nx = state_q;
        unique case (state_q)
            RD_FILL: begin
                if (level >= START_LV) state_nx = RD_RUN;
            end
            RD_RUN: begin
                take     = rd_slot && !empty;
                urn_cond = rd_slot && empty;
            end
            default: state_nx = RD_FILL;
        endcase
        rbin_nx = take ? rbin_q + 1'b1 : rbin_q;
    end

    // State register
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) state_q <= RD_FILL;
        else         state_q <= state_nx;
    end

    // Outputs and read position
    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin_q   <= '0;
            rgray    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            urn_hit  <= 1'b0;
        end else begin
            rbin_q   <= rbin_nx;
            rgray    <= rbin_nx ^ (rbin_nx >> 1);
            rd_valid <= take;
            urn_hit  <= urn_cond;
            if (take) rd_data <= mem_rdata;
        end
    end

    assign mem_raddr = rbin_q[ADDR_W-1:0];

    // R2: no byte leaves while still filling
    a_r2_fill_blocks_output: assert property (@(posedge rclk) disable iff (!rrst_n)
        (state_q == RD_FILL) |=> !rd_valid);

    // R3: each delivered byte advances the read position by exactly one
    a_r3_step_one: assert property (@(posedge rclk) disable iff (!rrst_n)
        take |=> (rbin_q == PTR_W'($past(rbin_q) + 1'b1)));

    // R6: underrun holds data and position
    a_r6_hold_on_underrun: assert property (@(posedge rclk) disable iff (!rrst_n)
        urn_cond |=> (!rd_valid && $stable(rd_data) && $stable(rbin_q)));

    // R9: streaming never falls back to filling
    a_r9_stay_run: assert property (@(posedge rclk) disable iff (!rrst_n)
        (state_q == RD_RUN) |=> (state_q == RD_RUN));
endmodule

// File: rtl/bl_evt.sv
module bl_evt
    import bl_pkg::*;
(
    input  logic rclk,
    input  logic rrst_n,
    input  logic hit,
    input  logic clr,
    output logic evt
);
    evt_state_t state_q;
    evt_state_t state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            EV_CLEAN:   if (hit)         state_nx = EV_LATCHED;
            EV_LATCHED: if (clr && !hit) state_nx = EV_CLEAN;
            default:                     state_nx = EV_CLEAN;
        endcase
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) state_q <= EV_CLEAN;
        else         state_q <= state_nx;
    end

    always_comb evt = (state_q == EV_LATCHED);

    // R7: event stays set without a clear
    a_r7_sticky: assert property (@(posedge rclk) disable iff (!rrst_n)
        (evt && !clr) |=> evt);

    // R8: a collision beats a simultaneous clear
    a_r8_set_wins: assert property (@(posedge rclk) disable iff (!rrst_n)
        hit |=> evt);
endmodule

// File: rtl/byte_link_fifo.sv
module byte_link_fifo
    import bl_pkg::*;
#(
    parameter int unsigned DATA_W      = BL_DATA_W,
    parameter int unsigned ADDR_W      = BL_ADDR_W,
    parameter int unsigned SYNC_N      = BL_SYNC_N,
    parameter int unsigned START_LEVEL = (1 << (BL_ADDR_W - 1))
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_slot,
    input  logic              evt_clr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              collide,
    output logic              evt_flag
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wgray;
    logic [PTR_W-1:0]  rgray;
    logic [PTR_W-1:0]  wgray_s;
    logic [PTR_W-1:0]  rgray_s;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              ovr_hit;
    logic              ovr_seen;
    logic              urn_cond;
    logic              urn_hit;

    bl_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .wclk       (wclk),
        .wrst_n     (wrst_n),
        .wr_valid   (wr_valid),
        .rgray_sync (rgray_s),
        .wgray      (wgray),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .ovr_hit    (ovr_hit)
    );

    bl_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    bl_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_w2r (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    bl_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_r2w (
        .clk   (wclk),
        .rst_n (wrst_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    bl_sync #(.W(1), .STAGES(SYNC_N)) u_ovr2r (
        .clk   (rclk),
        .rst_n (rrst_n),
        .d     (ovr_hit),
        .q     (ovr_seen)
    );

    bl_rd_side #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .START_LEVEL (START_LEVEL)
    ) u_rd (
        .rclk       (rclk),
        .rrst_n     (rrst_n),
        .rd_slot    (rd_slot),
        .wgray_sync (wgray_s),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rgray      (rgray),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .urn_cond   (urn_cond),
        .urn_hit    (urn_hit)
    );

    bl_evt u_evt (
        .rclk   (rclk),
        .rrst_n (rrst_n),
        .hit    (urn_cond | ovr_seen),
        .clr    (evt_clr),
        .evt    (evt_flag)
    );

    assign collide = ovr_hit | urn_hit;
endmodule

// File: tb/byte_link_fifo_tb_top.sv
`timescale 1ns/100ps
module byte_link_fifo_tb_top;
    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       wrst_n = 1'b0;
    logic       rrst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_slot = 1'b0;
    logic       evt_clr = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       collide;
    logic       evt_flag;

    int total = 0;
    int bad = 0;
    int wseq = 0;
    logic [7:0] model_q[$];
    logic [7:0] last_byte;

    // bursts: [15:8] bytes written, [7:0] slots requested
    localparam logic [15:0] PLAN [6] = '{
        16'h0A14, 16'h1E05, 16'h0028, 16'h3232, 16'h071E, 16'h1419
    };

    byte_link_fifo dut_i (
        .wclk(wclk), .wrst_n(wrst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rclk(rclk), .rrst_n(rrst_n), .rd_slot(rd_slot), .evt_clr(evt_clr),
        .rd_valid(rd_valid), .rd_data(rd_data), .collide(collide), .evt_flag(evt_flag)
    );

    always #2 wclk = ~wclk;
    initial begin
        #1.3;
        forever #2 rclk = ~rclk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] gen_byte();
        logic [7:0] b;
        b = 8'(wseq * 29 + 11);
        wseq++;
        return b;
    endfunction

    task automatic do_reset();
        wr_valid = 1'b0; rd_slot = 1'b0; evt_clr = 1'b0;
        wrst_n = 1'b0; rrst_n = 1'b0;
        model_q.delete();
        repeat (4) @(negedge wclk);
        wrst_n = 1'b1;
        @(negedge rclk);
        rrst_n = 1'b1;
    endtask

    task automatic write_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_valid = 1'b1;
            wr_data  = gen_byte();
            model_q.push_back(wr_data);
        end
        @(negedge wclk);
        wr_valid = 1'b0;
    endtask

    task automatic read_burst(input int n, input string req);
        if (n > 0) begin
            @(negedge rclk);
            rd_slot = 1'b1;
            for (int i = 0; i < n; i++) begin
                logic [7:0] e;
                @(negedge rclk);
                if (i == n - 1) rd_slot = 1'b0;
                e = (model_q.size() > 0) ? model_q.pop_front() : 8'h00;
                chk({req, " valid"}, {31'd0, rd_valid}, 32'd1);
                chk({req, " data"}, {24'd0, rd_data}, {24'd0, e});
                last_byte = e;
            end
        end
    endtask

    task automatic idle_r(input int n);
        repeat (n) @(negedge rclk);
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        total++; bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge rclk);
        chk("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        chk("R1 collide in reset", {31'd0, collide}, 32'd0);
        do_reset();
        idle_r(2);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1 rd_data", {24'd0, rd_data}, 32'd0);
        chk("R1 collide", {31'd0, collide}, 32'd0);
        chk("R1 evt_flag", {31'd0, evt_flag}, 32'd0);

        // R2: below half level, slots are ignored
        write_burst(63);
        idle_r(10);
        @(negedge rclk); rd_slot = 1'b1;
        repeat (3) begin
            @(negedge rclk);
            chk("R2 no output while filling", {31'd0, rd_valid}, 32'd0);
            chk("R2 no underrun while filling", {31'd0, collide}, 32'd0);
        end
        rd_slot = 1'b0;
        idle_r(2);
        chk("R2 no event while filling", {31'd0, evt_flag}, 32'd0);

        // R3: table of bursts after reaching half level
        write_burst(1);
        idle_r(10);
        for (int k = 0; k < 6; k++) begin
            write_burst(int'(PLAN[k][15:8]));
            idle_r(10);
            read_burst(int'(PLAN[k][7:0]), "R3 order");
            chk("R3 no collision in table", {31'd0, collide}, 32'd0);
        end

        // drain, then R6 underrun
        read_burst(model_q.size(), "R3 drain");
        idle_r(2);
        @(negedge rclk); rd_slot = 1'b1;
        @(negedge rclk); rd_slot = 1'b0;
        chk("R6 underrun no valid", {31'd0, rd_valid}, 32'd0);
        chk("R6 underrun holds data", {24'd0, rd_data}, {24'd0, last_byte});
        chk("R6 underrun collide", {31'd0, collide}, 32'd1);
        chk("R7 event set by underrun", {31'd0, evt_flag}, 32'd1);
        idle_r(5);
        chk("R7 event sticky", {31'd0, evt_flag}, 32'd1);
        chk("R6 collide drops after underrun", {31'd0, collide}, 32'd0);

        // R8: clear and collision together, then clear alone
        rd_slot = 1'b1; evt_clr = 1'b1;
        @(negedge rclk);
        rd_slot = 1'b0;
        chk("R8 set wins over clear", {31'd0, evt_flag}, 32'd1);
        chk("R8 collide with clear", {31'd0, collide}, 32'd1);
        @(negedge rclk);
        evt_clr = 1'b0;
        chk("R8 clear alone", {31'd0, evt_flag}, 32'd0);
        chk("R8 collide idle", {31'd0, collide}, 32'd0);

        // R9: no refill needed after underrun
        write_burst(1);
        idle_r(10);
        read_burst(1, "R9 after underrun");

        // R4: continuous streaming at half level
        write_burst(64);
        idle_r(10);
        for (int i = 0; i < 100; i++) begin
            @(negedge wclk);
            wr_valid = 1'b1;
            wr_data  = gen_byte();
            model_q.push_back(wr_data);
            @(negedge rclk);
            if (i > 0) begin
                logic [7:0] e;
                e = model_q.pop_front();
                chk("R4 stream valid", {31'd0, rd_valid}, 32'd1);
                chk("R4 stream data", {24'd0, rd_data}, {24'd0, e});
                chk("R4 stream collide", {31'd0, collide}, 32'd0);
            end
            rd_slot = 1'b1;
        end
        @(negedge wclk); wr_valid = 1'b0;
        @(negedge rclk);
        rd_slot = 1'b0;
        begin
            logic [7:0] e;
            e = model_q.pop_front();
            chk("R4 stream last", {24'd0, rd_data}, {24'd0, e});
        end
        idle_r(4);
        chk("R4 no event", {31'd0, evt_flag}, 32'd0);

        // R5: overrun
        do_reset();
        write_burst(128);
        chk("R5 full but no collision", {31'd0, collide}, 32'd0);
        wr_valid = 1'b1; wr_data = gen_byte();
        @(negedge wclk);
        chk("R5 overrun collide", {31'd0, collide}, 32'd1);
        wr_data = gen_byte();
        @(negedge wclk);
        chk("R5 collide holds", {31'd0, collide}, 32'd1);
        wr_valid = 1'b0;
        @(negedge wclk);
        chk("R5 collide ends", {31'd0, collide}, 32'd0);
        idle_r(10);
        chk("R7 event set by overrun", {31'd0, evt_flag}, 32'd1);
        read_burst(128, "R5 content kept");
        idle_r(4);
        chk("R5 all read", {32'(model_q.size())}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule